// File: doc/BRIEF.md
# Timestamp Record Readout Port

This block keeps the event timestamp records that a capture engine produces for a set of network ports, in both directions. Each port and direction has its own channel with a small record queue. A host drains the queue through a 32-bit register read interface. A record is 192 bits wide and is never read in one access. Instead it comes out as twelve 16-bit words through a single data register that removes them as they are read. Each read returns one word in the low half of the bus.

Each channel has a status register. It shows whether the channel accepts new records, which word of the head record the next data read will return, and how many records were lost because the queue was full. One global register collects a not-empty flag for every channel, so a host can poll once and then read only the channels that hold data.

The low 3 bits of the tag word carry the event message type: 1 Sync, 2 Pdelay_Req, 3 Pdelay_Resp, 4 Delay_Req. The block passes these bits through without looking at them.

Top module: `ts_readout_top`

## Requirements
- R1: After reset, every status register, the buffer-status register and `rd_data` read as 0. This means capture is disabled, the word position is 0 and the discard count is 0.
- R2: The buffer-status register is at byte address 0x04. Port p has a window at 0x20 + 0x20·p. Inside that window, transmit status is at +0x0, receive status at +0x4, transmit data at +0x8 and receive data at +0xC. A read of any other address returns 0.
- R3: The capture bus of channel c is `cap_data[c*192 +: 192]`, packed from MSB down as tag(16), seconds(48), nanoseconds(32), clock identity(64), port number(16), sequence ID(16). The twelve data reads of one record return, in bits 15:0, the tag word, then the 3 seconds words, the 2 nanoseconds words, the 4 clock-identity words, the port-number word and the sequence-ID word. Every multi-word field comes most significant word first. Bits 31:16 are 0.
- R4: Status bits 12:8 hold the word position. It is 0 when the next data read returns a tag word, and it rises by one with each data read of a non-empty channel.
- R5: The read of word 11 removes the record from the queue and sets the position back to 0, so the next read starts the following record.
- R6: Status bit 15 is the capture enable. A write to a status register loads bit 15 from `wr_data[15]` and ignores every other written bit. While the enable is 0, arriving records are neither stored nor counted.
- R7: A record that arrives while the channel is enabled and its queue already holds DEPTH records is dropped. Status bits 7:4 count such drops and stay at 15 once they reach it.
- R8: A data read of an empty channel returns 0 and leaves the word position unchanged.
- R9: Buffer-status bit p is set when the transmit queue of port p is not empty. Bit NUM_PORTS+p does the same for the receive queue of port p. All other bits are 0.
- R10: Records leave each queue in arrival order, and the queue holds up to DEPTH records.
- R11: `rd_valid` is high in the cycle after every `rd_en` cycle, and `rd_data` then holds the addressed value. Between reads, `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_valid | input | 2·NUM_PORTS | One strobe per channel; transmit channels come first |
| cap_data | input | 2·NUM_PORTS·192 | Captured records, one 192-bit slice per channel |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Byte address of the read |
| rd_data | output | 32 | Read result, registered |
| rd_valid | output | 1 | High one cycle after a read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 32 | Write data; only bit 15 is used |

## Verification
Several rules are checked on every cycle by assertions:
- the word position never passes 11, and it is non-zero only while the queue holds data;
- a read of an empty queue leaves the position where it was;
- a removal is followed by position 0;
- the discard count only ever steps up by one;
- a disabled, empty queue stays empty;
- the queue never overflows or underflows.

The word order, the most-significant-first layout, the address map, the first-in first-out order and the saturation at 15 can only be shown by the bench's sweeps. For every channel, the bench rebuilds the expected words from the field values it packed itself.

// File: rtl/ts_readout_pkg.sv
package ts_readout_pkg;

  localparam int WORD_W    = 16;
  localparam int REC_WORDS = 12;
  localparam int REC_W     = WORD_W * REC_WORDS;
  localparam int POS_W     = 5;
  localparam int DISC_W    = 4;

  localparam logic [POS_W-1:0]  LAST_POS = POS_W'(REC_WORDS - 1);
  localparam logic [DISC_W-1:0] DISC_MAX = '1;

  localparam int BUFSTAT_OFF = 'h04;
  localparam int PORT_BASE   = 'h20;
  localparam int PORT_WIN    = 'h20;
  localparam int RX_OFF      = 'h4;
  localparam int DATA_OFF    = 'h8;

  // word k of a record, most significant word first
  function automatic logic [WORD_W-1:0] rec_word(logic [REC_W-1:0] rec,
                                                 logic [POS_W-1:0] pos);
    logic [REC_W-1:0] sh;
    if (pos > LAST_POS) return '0;
    sh = rec >> (WORD_W * (int'(LAST_POS) - int'(pos)));
    return sh[WORD_W-1:0];
  endfunction

  function automatic logic [DISC_W-1:0] sat_inc(logic [DISC_W-1:0] v);
    return (v == DISC_MAX) ? v : v + 1'b1;
  endfunction

  // status layout: [15] enable, [12:8] position, [7:4] discards
  function automatic logic [31:0] status_word(logic en, logic [POS_W-1:0] pos,
                                              logic [DISC_W-1:0] disc);
    return 32'({en, 2'b00, pos, disc, 4'b0000});
  endfunction

  function automatic int chan_addr(int port, bit is_rx, bit is_data);
    return PORT_BASE + port * PORT_WIN + (is_rx ? RX_OFF : 0) + (is_data ? DATA_OFF : 0);
  endfunction

endpackage

// File: rtl/ts_rec_fifo.sv
module ts_rec_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 192
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] level;

  assign full  = (level == LVL_FULL);
  assign empty = (level == '0);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R5

endmodule

// File: rtl/ts_chan.sv
module ts_chan
  import ts_readout_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_valid,
  input  logic [REC_W-1:0] cap_rec,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             data_rd,
  output logic [31:0]      data_word,
  output logic [31:0]      stat_word,
  output logic             not_empty
);
  logic              enable;
  logic [POS_W-1:0]  pos;
  logic [DISC_W-1:0] disc;
  logic [REC_W-1:0]  head;
  logic              full, empty;

  // named events
  logic accept_evt, push_evt, drop_evt, hit_evt, pop_evt;
  assign accept_evt = cap_valid & enable;
  assign push_evt   = accept_evt & ~full;
  assign drop_evt   = accept_evt & full;
  assign hit_evt    = data_rd & ~empty;
  assign pop_evt    = hit_evt & (pos == LAST_POS);

  ts_rec_fifo #(.DEPTH(DEPTH), .W(REC_W)) i_fifo (
    .clk(clk), .rst(rst), .push(push_evt), .push_data(cap_rec),
    .pop(pop_evt), .head(head), .full(full), .empty(empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      pos    <= '0;
      disc   <= '0;
    end else begin
      if (en_wr)    enable <= en_val;
      if (pop_evt)  pos    <= '0;
      else if (hit_evt) pos <= pos + 1'b1;
      if (drop_evt) disc   <= sat_inc(disc);
    end
  end

  assign data_word = empty ? 32'h0 : 32'(rec_word(head, pos));
  assign stat_word = status_word(enable, pos, disc);
  assign not_empty = ~empty;

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST_POS); // R4
  AST_POS_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    (pos != '0) |-> !empty); // R4
  AST_EMPTY_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (data_rd && empty) |=> $stable(pos)); // R8
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    pop_evt |=> (pos == '0)); // R5
  AST_DISC_STEP: assert property (@(posedge clk) disable iff (rst)
    (disc != $past(disc)) |-> (disc == $past(disc) + 1'b1)); // R7
  AST_OFF_STAYS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!enable && empty) |=> empty); // R6

endmodule

// File: rtl/ts_readout_top.sv
module ts_readout_top
  import ts_readout_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int DEPTH     = 4,
  parameter int AW        = 8,
  localparam int NCH      = 2 * NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       cap_valid,
  input  logic [NCH*REC_W-1:0] cap_data,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  output logic [31:0]          rd_data,
  output logic                 rd_valid,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [31:0]          wr_data
);
  localparam logic [AW-1:0] BUF_A = AW'(BUFSTAT_OFF);

  logic [31:0]    stat_w [NCH];
  logic [31:0]    data_w [NCH];
  logic [NCH-1:0] ne, sel_stat, sel_data, data_rd, en_wr;
  logic [31:0]    rd_mux;
  logic           unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[31:16], wr_data[14:0]};

  // channel c < NUM_PORTS: transmit of port c; else receive of port c-NUM_PORTS
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam bit IS_RX = (c >= NUM_PORTS);
    localparam int PORT  = c % NUM_PORTS;
    localparam logic [AW-1:0] STAT_A = AW'(chan_addr(PORT, IS_RX, 1'b0));
    localparam logic [AW-1:0] DATA_A = AW'(chan_addr(PORT, IS_RX, 1'b1));

    assign sel_stat[c] = (rd_addr == STAT_A);
    assign sel_data[c] = (rd_addr == DATA_A);
    assign data_rd[c]  = rd_en & sel_data[c];
    assign en_wr[c]    = wr_en & (wr_addr == STAT_A);

    ts_chan #(.DEPTH(DEPTH)) i_chan (
      .clk(clk), .rst(rst),
      .cap_valid(cap_valid[c]), .cap_rec(cap_data[c*REC_W +: REC_W]),
      .en_wr(en_wr[c]), .en_val(wr_data[15]),
      .data_rd(data_rd[c]),
      .data_word(data_w[c]), .stat_word(stat_w[c]), .not_empty(ne[c])
    );
  end

  always_comb begin
    rd_mux = (rd_addr == BUF_A) ? 32'(ne) : 32'h0;
    for (int c = 0; c < NCH; c++) begin
      if (sel_stat[c]) rd_mux = rd_mux | stat_w[c];
      if (sel_data[c]) rd_mux = rd_mux | data_w[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R11
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_stat, sel_data, rd_addr == BUF_A})); // R2

endmodule

// File: tb/test_ts_readout_top.sv
`timescale 1ns/1ps
module test_ts_readout_top;
  localparam int NP  = 3;
  localparam int DEP = 4;
  localparam int NCH = 2 * NP;
  localparam int RW  = 192;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCH-1:0]  cap_valid = '0;
  logic [NCH*RW-1:0] cap_data = '0;
  logic            rd_en = 1'b0;
  logic [7:0]      rd_addr = '0;
  logic [31:0]     rd_data;
  logic            rd_valid;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_addr = '0;
  logic [31:0]     wr_data = '0;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ts_readout_top #(.NUM_PORTS(NP), .DEPTH(DEP), .AW(8)) i_ts_readout_top (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_data(cap_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_a(int ch);
    return 8'(32 + 32 * (ch % NP) + ((ch >= NP) ? 4 : 0));
  endfunction
  function automatic logic [7:0] data_a(int ch);
    return 8'(32 + 32 * (ch % NP) + ((ch >= NP) ? 12 : 8));
  endfunction

  function automatic logic [15:0]  f_tag(int ch, int n); return 16'((ch << 8) | (n << 3) | (n % 4 + 1)); endfunction
  function automatic logic [47:0]  f_sec(int ch, int n); return 48'(ch * 1000003 + n * 7919) ^ 48'hA5A5_0000_0000; endfunction
  function automatic logic [31:0]  f_ns (int ch, int n); return 32'(n * 123456789 + ch); endfunction
  function automatic logic [63:0]  f_clk(int ch, int n); return 64'h0011_2233_4455_6677 + (64'(ch) << 40) + 64'(n); endfunction
  function automatic logic [15:0]  f_prt(int ch);        return 16'(ch + 1); endfunction
  function automatic logic [15:0]  f_seq(int ch, int n); return 16'(n * 3 + ch); endfunction

  function automatic logic [31:0] exp_word(int ch, int n, int k);
    logic [63:0] v;
    if (k == 0)      v = 64'(f_tag(ch, n));
    else if (k <= 3) v = 64'(f_sec(ch, n)) >> (16 * (3 - k));
    else if (k <= 5) v = 64'(f_ns(ch, n))  >> (16 * (5 - k));
    else if (k <= 9) v = f_clk(ch, n)      >> (16 * (9 - k));
    else if (k == 10) v = 64'(f_prt(ch));
    else             v = 64'(f_seq(ch, n));
    return {16'h0, v[15:0]};
  endfunction

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 rd_valid", 32'(rd_valid), 32'h1);
    d = rd_data;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(int ch, int n);
    @(negedge clk);
    cap_valid[ch] = 1'b1;
    cap_data[ch*RW +: RW] = {f_tag(ch, n), f_sec(ch, n), f_ns(ch, n), f_clk(ch, n), f_prt(ch), f_seq(ch, n)};
    @(negedge clk);
    cap_valid = '0;
  endtask

  function automatic logic [31:0] stat(bit en, int pos, int disc);
    return 32'(((en ? 1 : 0) << 15) | (pos << 8) | (disc << 4));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rd_data after reset", rd_data, 32'h0);
    chk("R11 rd_valid idle", 32'(rd_valid), 32'h0);
    do_rd(8'h04, d); chk("R1 bufstat reset", d, 32'h0);
    for (int ch = 0; ch < NCH; ch++) begin
      do_rd(stat_a(ch), d); chk("R1 status reset", d, 32'h0);
    end
    do_rd(8'h10, d); chk("R2 unmapped read", d, 32'h0);
    do_rd(8'h70, d); chk("R2 unmapped read above ports", d, 32'h0);

    // disabled channel ignores records
    for (int ch = 0; ch < NCH; ch++) begin
      push(ch, 0);
      do_rd(8'h04, d);       chk("R6 disabled not stored", d, 32'h0);
      do_rd(stat_a(ch), d);  chk("R6 disabled not counted", d, 32'h0);
      do_wr(stat_a(ch), 32'hFFFF_7FFF & 32'h0000_9FF3 | 32'h8000);
      do_rd(stat_a(ch), d);  chk("R6 enable bit only", d, stat(1, 0, 0));
    end

    // full record readout sweep on every channel
    for (int ch = 0; ch < NCH; ch++) begin
      push(ch, 1);
      push(ch, 2);
      do_rd(8'h04, d); chk("R9 bufstat one channel", d, 32'(1 << ch));
      for (int n = 1; n <= 2; n++) begin
        for (int k = 0; k < 12; k++) begin
          do_rd(data_a(ch), d); chk("R3 R10 record word", d, exp_word(ch, n, k));
          do_rd(stat_a(ch), d); chk("R4 R5 position", d, stat(1, (k + 1) % 12, 0));
        end
      end
      do_rd(8'h04, d);       chk("R9 bufstat drained", d, 32'h0);
      do_rd(data_a(ch), d);  chk("R8 empty read zero", d, 32'h0);
      do_rd(stat_a(ch), d);  chk("R8 empty read position", d, stat(1, 0, 0));
    end

    // overflow and saturation, oldest records kept
    for (int ch = 0; ch < NCH; ch++) begin
      for (int n = 0; n < DEP + 3; n++) push(ch, 10 + n);
      do_rd(stat_a(ch), d); chk("R7 discard count", d, stat(1, 0, 3));
      for (int n = 0; n < 14; n++) push(ch, 40);
      do_rd(stat_a(ch), d); chk("R7 discard saturates", d, stat(1, 0, 15));
      // partial read then check position
      for (int k = 0; k < 5; k++) begin
        do_rd(data_a(ch), d); chk("R3 partial word", d, exp_word(ch, 10, k));
      end
      do_rd(stat_a(ch), d); chk("R4 mid-record position", d, stat(1, 5, 15));
      for (int k = 5; k < 12; k++) begin
        do_rd(data_a(ch), d); chk("R5 finish record", d, exp_word(ch, 10, k));
      end
      for (int n = 1; n < DEP; n++) begin
        for (int k = 0; k < 12; k++) begin
          do_rd(data_a(ch), d); chk("R10 fifo order", d, exp_word(ch, 10 + n, k));
        end
      end
      do_rd(8'h04, d); chk("R9 empty after overflow drain", d, 32'h0);
      // disable again: no store, count unchanged
      do_wr(stat_a(ch), 32'h0000_7FFF);
      push(ch, 50);
      do_rd(stat_a(ch), d); chk("R6 disabled again", d, stat(0, 0, 15));
      do_rd(8'h04, d);      chk("R6 disabled bufstat", d, 32'h0);
    end

    // rd_data holds between reads
    @(negedge clk);
    chk("R11 rd_data hold", rd_data, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule